// File: doc/BRIEF.md
# MDIO Management Command Engine

This block runs one clause-22 management transaction at a time on the MDC/MDIO pins of a PHY. Software sees it as two 16-bit registers. The control register takes a packed command. The data register holds the outgoing write value and receives the returned read value. Writing the control register while the engine is idle starts the serial frame immediately. A sticky finished flag in bit 15 of the control register goes low for the length of the frame and then returns high. Software polls that flag before it issues a command and again before it collects a read result.

MDC is made from the system clock. It stays low for `HALF_DIV` cycles and then high for `HALF_DIV` cycles. The engine changes what it drives while MDC is low and samples the PHY on the rising MDC edge. Every frame is exactly 64 MDC periods long. The register port is a plain single-cycle write strobe with continuous read-back, so it applies no back-pressure: a command refused because the engine is busy is simply dropped.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, the control read-back is 16'h8000 (finished flag set, all fields zero), the data read-back is 0, MDC is low and MDIO is not driven.
- R2: A control write (reg_sel=1) while the finished flag is set starts a transaction. The flag reads 0 on the following cycle. The read-back then shows the stored command: bit 13 is the write select, bits [12:8] are the PHY address and bits [4:0] are the register number.
- R3: Each frame, in transmit order, is 32 ones, then 0,1, then the opcode (1,0 for read and 0,1 for write), then the 5-bit PHY address MSB first, then the 5-bit register number MSB first.
- R4: A write frame continues with the turnaround 1,0 and then the 16 data bits MSB first. The data bits are the data register contents at the moment of launch, and a data-register write during the frame does not change them.
- R5: In a read frame, MDIO is released from the turnaround (frame bit 46) to the last bit. The 16 bits sampled on the rising MDC edges of frame bits 48..63, MSB first, appear in the data register when the frame ends.
- R6: While a frame runs, MDC alternates low and high phases of HALF_DIV system cycles each, starting low. While idle, MDC is low. MDIO output and output enable change only while MDC is low.
- R7: The finished flag returns to 1 exactly 128*HALF_DIV cycles after the launching edge, at the falling MDC edge that ends bit 63.
- R8: A control write while the finished flag is clear is ignored: the command read-back and the frame on the pins are unchanged, and the flag stays clear.
- R9: If a data-register write lands on the same edge as a read completion, the PHY value wins. On a later cycle the data write takes effect normally.
- R10: Control-word bits 15, 14 and 7:5 are ignored on write, and bits 14 and 7:5 read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | 1 selects the control register, 0 the data register |
| reg_wdata | input | 16 | Write value |
| ctrl_rd | output | 16 | Control read-back: finished flag, write select, PHY address, register number |
| data_rd | output | 16 | Data register read-back |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, 1 drives the line |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The data register has two writers. A read completion loads the PHY value into it, and a software write loads the write value. Both can land on the same clock edge. The bench counts cycles from the launching edge so that a data write is sampled on exactly the completion edge, 128*HALF_DIV cycles later, and then expects the PHY reply rather than the written value. A second write, issued afterwards, must then show up. The bench also overlaps a refused control write, and a data write, with frames in flight, and compares each full captured frame against the one expected from the launch.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;

  typedef struct packed {
    logic       wr;
    logic [4:0] phy;
    logic [4:0] regn;
  } mdio_cmd_t;

  // frame bit k sits at vector position FRAME_BITS-1-k
  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (c.wr ? 2'b01 : 2'b10), c.phy, c.regn,
            (c.wr ? 2'b10 : 2'b00), (c.wr ? d : 16'h0000)};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign rise = run && (cnt == LAST) && !mdc;
  assign fall = run && (cnt == LAST) && mdc;
endmodule

// File: rtl/mdio_sequencer.sv
module mdio_sequencer
  import mdio_cmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  is_wr,
  input  logic                  rise,
  input  logic                  fall,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic [15:0]           rx_data,
  output logic                  last
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] TA_IDX   = IW'(TA_POS);
  localparam logic [IW-1:0] DATA_IDX = IW'(DATA_POS);
  localparam logic [IW-1:0] END_IDX  = IW'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] shreg;
  logic [IW-1:0]         idx;
  logic                  wr_q;

  assign last    = fall && (idx == END_IDX);
  assign mdio_o  = busy && shreg[FRAME_BITS-1];
  assign mdio_oe = busy && (wr_q || (idx < TA_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      shreg   <= '0;
      idx     <= '0;
      wr_q    <= 1'b0;
      rx_data <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      shreg <= frame;
      idx   <= '0;
      wr_q  <= is_wr;
    end else if (busy) begin
      if (rise && (idx >= DATA_IDX))
        rx_data <= {rx_data[14:0], mdio_i};
      if (fall) begin
        shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
        idx   <= idx + 1'b1;
        if (idx == END_IDX)
          busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_cmd_pkg::*;
#(
  parameter int HALF_DIV = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] ctrl_rd,
  output logic [15:0] data_rd,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_cmd_t  cmd_q, cmd_new;
  logic       done_q;
  logic [15:0] data_q;
  logic       start, busy, rise, fall, last;
  logic [15:0] rx_data;

  assign cmd_new = '{wr: reg_wdata[13], phy: reg_wdata[12:8], regn: reg_wdata[4:0]};
  assign start   = reg_wr && reg_sel && done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      done_q <= 1'b1;
      data_q <= '0;
    end else begin
      if (start) begin
        cmd_q  <= cmd_new;
        done_q <= 1'b0;
      end else if (last) begin
        done_q <= 1'b1;
      end
      if (last && !cmd_q.wr)
        data_q <= rx_data;
      else if (reg_wr && !reg_sel)
        data_q <= reg_wdata;
    end
  end

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .frame(build_frame(cmd_new, data_q)), .is_wr(cmd_new.wr),
    .rise(rise), .fall(fall), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rx_data(rx_data), .last(last)
  );

  assign ctrl_rd = {done_q, 1'b0, cmd_q.wr, cmd_q.phy, 3'b000, cmd_q.regn};
  assign data_rd = data_q;
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk #(
  parameter int HALF_DIV = 50
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic [15:0] ctrl_rd,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  logic        mdc_q;
  logic [31:0] cyc;
  logic [7:0]  rises;
  logic        launch, toggled;

  assign launch  = reg_wr && reg_sel && ctrl_rd[15];
  assign toggled = (mdc != mdc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q <= 1'b0;
      cyc   <= '0;
      rises <= '0;
    end else begin
      mdc_q <= mdc;
      if (launch) begin
        cyc   <= '0;
        rises <= '0;
      end else begin
        cyc <= toggled ? 32'd1 : cyc + 32'd1;
        if (mdc && !mdc_q)
          rises <= rises + 8'd1;
      end
    end
  end

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[15] |-> (!mdc && !mdio_oe)); // R6
  AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !ctrl_rd[15]); // R2
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && !ctrl_rd[15]) |=> $stable(ctrl_rd[13:0])); // R8
  AST_DRIVE_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe))); // R6
  AST_MDC_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rd[15] && toggled) |-> (cyc == 32'(HALF_DIV))); // R6
  AST_TA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rd[15] && !ctrl_rd[13] && rises >= 8'd47) |-> !mdio_oe); // R5
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .ctrl_rd(ctrl_rd), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_cmd_engine_test.sv
module mdio_cmd_engine_test;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] ctrl_rd, data_rd;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int total = 0, bad = 0;
  logic [63:0] exp_q[$];
  logic [63:0] mask_q[$];
  logic [63:0] cap_v = '0, cap_oe = '0;
  int rc = 0;
  logic [15:0] reply = '0;

  always #2 clk = ~clk;

  mdio_cmd_engine #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rd(ctrl_rd), .data_rd(data_rd),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic reg_write(logic sel, logic [15:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // driver: push expected frame, then launch
  task automatic issue(logic wr, logic [4:0] phy, logic [4:0] rn, logic [15:0] d);
    exp_q.push_back({32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rn,
                     (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0)});
    mask_q.push_back(wr ? {64{1'b1}} : {{46{1'b1}}, 18'h0});
    reg_write(1'b1, {2'b00, wr, phy, 3'b000, rn});
  endtask

  task automatic wait_done();
    while (!ctrl_rd[15]) @(negedge clk);
  endtask

  // monitor: capture every bit on rising MDC, compare after 64 bits
  always @(posedge mdc) begin
    cap_v  = {cap_v[62:0], mdio_o};
    cap_oe = {cap_oe[62:0], mdio_oe};
    rc++;
    if (rc == 64) begin
      rc = 0;
      if (exp_q.size() == 0) begin
        check("R3 unexpected frame", 64'd1, 64'd0);
      end else begin
        logic [63:0] e, m;
        e = exp_q.pop_front();
        m = mask_q.pop_front();
        check("R3 R4 frame bits", cap_v & m, e & m);
        check("R5 output enable pattern", cap_oe, m);
      end
    end
  end

  // PHY model: present read data after each falling MDC edge
  always @(negedge mdc) begin
    if (rc >= 48 && rc <= 63) mdio_i = reply[63 - rc];
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 ctrl reset", ctrl_rd, 16'h8000);
    check("R1 data reset", data_rd, 16'h0000);
    check("R1 idle pins", {mdc, mdio_oe}, 2'b00);

    // T1: write, timing of completion (R2, R7)
    reg_write(1'b0, 16'hA5C3);
    issue(1'b1, 5'h11, 5'h0A, 16'hA5C3);
    check("R2 readback after launch", ctrl_rd, {3'b001, 5'h11, 3'b000, 5'h0A});
    n = 0;
    while (!ctrl_rd[15]) begin n++; @(negedge clk); end
    check("R7 busy length", n, 128 * HALF);
    check("R4 data kept after write", data_rd, 16'hA5C3);

    // T2: read, MDC phase, ignored control write (R5, R6, R8)
    reply = 16'hBEEF;
    issue(1'b0, 5'h05, 5'h1F, 16'h0);
    @(posedge mdc);
    n = 0;
    @(negedge clk);
    while (mdc) begin n++; @(negedge clk); end
    check("R6 mdc high phase", n, HALF);
    n = 0;
    while (!mdc) begin n++; @(negedge clk); end
    check("R6 mdc low phase", n, HALF);
    reg_write(1'b1, 16'h2A1B);
    check("R8 busy ctrl write ignored", ctrl_rd, {3'b000, 5'h05, 3'b000, 5'h1F});
    wait_done();
    check("R5 read result", data_rd, 16'hBEEF);

    // T3: write, data changed mid-frame (R4)
    reg_write(1'b0, 16'h0F0F);
    issue(1'b1, 5'h1F, 5'h00, 16'h0F0F);
    repeat (40) @(negedge clk);
    reg_write(1'b0, 16'hFFFF);
    wait_done();
    check("R4 data write during frame lands", data_rd, 16'hFFFF);

    // T4: data write on completion edge (R9)
    reply = 16'h8001;
    issue(1'b0, 5'h0C, 5'h03, 16'h0);
    repeat (128 * HALF - 1) @(posedge clk);
    reg_write(1'b0, 16'h5555);
    check("R9 completion beats data write", data_rd, 16'h8001);
    check("R7 done at completion", ctrl_rd[15], 1'b1);
    reg_write(1'b0, 16'h5555);
    check("R9 later data write", data_rd, 16'h5555);

    // T5: reserved bits ignored (R10)
    reply = 16'h7FFE;
    exp_q.push_back({32'hFFFF_FFFF, 2'b01, 2'b10, 5'h00, 5'h03, 18'h0});
    mask_q.push_back({{46{1'b1}}, 18'h0});
    reg_write(1'b1, 16'hC0E3);
    check("R10 reserved bits read zero", ctrl_rd, 16'h0003);
    wait_done();
    check("R10 read executed", data_rd, 16'h7FFE);

    repeat (4) @(negedge clk);
    check("R3 all frames seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule